// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Demap Engine

This block is a small fully associative translation lookaside buffer for a memory management unit. Each entry pairs a tag (virtual page number plus a 10-bit context) with a 64-bit translation word. The translation word carries the physical page and the attribute bits: writable, privileged, cacheable-virtual, cacheable-physical, locked and valid. A lookup presents a virtual page and a context. One cycle later the block returns a hit flag, the matching translation word and its decoded attributes.

Software loads and inspects entries through a diagnostic port. It addresses an entry by its index shifted left by three, and a TLB-select field decides whether this array is the target. The block holds two context registers, primary and secondary, that software writes. A demap port takes a command address. The low bits of that address pick the operation and which context it uses: primary, secondary, or the fixed nucleus context zero. The operation is one of three: remove one page, remove one whole context, or remove every entry that is not locked. Every demap finishes in the cycle it is presented, so the busy output never rises.

Top module: `tlb_fa_demap`

## Requirements
- R1: After reset every entry is invalid, so all lookups miss. Both context registers read 0, and no lookup or diagnostic result is flagged valid.
- R2: One cycle after `lk_req`, `lk_rvalid` is high. A hit requires a valid entry (translation bit 63 set) whose virtual page and full 10-bit context both equal the request. On a hit, `lk_data` is the stored word unmodified and `lk_attr` = {bit 6 locked, bit 5 cacheable-physical, bit 4 cacheable-virtual, bit 2 privileged, bit 1 writable}. On a miss, `lk_hit`, `lk_data` and `lk_attr` are zero.
- R3: Entries with bit 63 clear never hit. When several valid entries match, the lowest-index entry is returned.
- R4: A context write with `ctx_sel`=0 loads the primary register and `ctx_sel`=1 loads the secondary register. Only the low 10 bits of `ctx_wdata` are kept.
- R5: The diagnostic address selects the entry with bits [IDX_W+2:3] and the target array with bits 17:16; only the value 0 targets this array. `dg_tag`=1 accesses the tag word, whose layout is {page in 63:13, zeros, context in 9:0}; `dg_tag`=0 accesses the translation word. A write whose select field is nonzero changes nothing, and a read with a nonzero select field returns 0. Read data appears one cycle after the request.
- R6: A diagnostic read of a translation word returns bits 49:41 as zero; all other bits are returned as stored.
- R7: Page demap (`dm_addr` bit 7 = 0, bit 6 = 0) invalidates each entry whose page equals `dm_addr`[63:13] and whose context equals the selected one. Bits 5:4 select the context: 0 primary, 1 secondary, 2 nucleus (0). Select value 3 has no effect.
- R8: Context demap (bit 7 = 0, bit 6 = 1) invalidates every entry whose context equals the selected context, whether or not it is locked.
- R9: Demap with bit 7 set (address 0x80) clears valid on every entry whose locked bit 6 is clear. Locked entries stay valid.
- R10: When a demap and a diagnostic write arrive in the same cycle, the demap takes effect and the write is dropped. `dm_busy` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 51 | Lookup virtual page number |
| lk_ctx | input | CTX_W | Lookup context |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | 64 | Matching translation word |
| lk_attr | output | 5 | {locked, cacheable-physical, cacheable-virtual, privileged, writable} |
| dg_req | input | 1 | Diagnostic access request |
| dg_we | input | 1 | Diagnostic write (1) or read (0) |
| dg_tag | input | 1 | Access tag word (1) or translation word (0) |
| dg_addr | input | DG_AW | Diagnostic address: index at bit 3, TLB-select at bit 16 |
| dg_wdata | input | 64 | Diagnostic write data |
| dg_rvalid | output | 1 | Diagnostic read data valid |
| dg_rdata | output | 64 | Diagnostic read data |
| ctx_we | input | 1 | Context register write |
| ctx_sel | input | 1 | 0 primary, 1 secondary |
| ctx_wdata | input | 64 | Context write data |
| pri_ctx | output | CTX_W | Primary context register |
| sec_ctx | output | CTX_W | Secondary context register |
| dm_req | input | 1 | Demap command strobe |
| dm_addr | input | 64 | Demap command address |
| dm_busy | output | 1 | Demap in progress (always 0) |

## Verification
The bench builds the block with its default parameters: 16 entries, a 10-bit context and a 20-bit diagnostic address. With 16 entries the last index, 15, can be loaded and looked up, and the 20-bit address reaches the TLB-select field at bits 17:16, so writes aimed at other arrays can be issued. The entries share tags and contexts, and the locked bit is mixed across them. This lets the bench try priority among duplicate matches and all three demap kinds under each context selector. It also covers the reserved selector and the case where a demap and a diagnostic write collide.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TTE_W   = 64;
  localparam int PG_SH   = 13;
  localparam int VPN_W   = TTE_W - PG_SH;

  // translation word attribute positions
  localparam int B_WR    = 1;
  localparam int B_PRIV  = 2;
  localparam int B_CV    = 4;
  localparam int B_CP    = 5;
  localparam int B_LOCK  = 6;
  localparam int B_VALID = 63;

  // diagnostic read blanking window
  localparam int DZ_LO   = 41;
  localparam int DZ_HI   = 49;

  // demap command address fields
  localparam int DM_ALL_BIT = 7;
  localparam int DM_CTX_BIT = 6;
  localparam int DM_SEL_LO  = 4;

  // diagnostic address fields
  localparam int DG_IDX_LO = 3;
  localparam int DG_SEL_LO = 16;

  typedef enum logic [1:0] {
    DM_NONE = 2'd0,
    DM_PAGE = 2'd1,
    DM_CTX  = 2'd2,
    DM_ALL  = 2'd3
  } dm_kind_e;

  typedef enum logic [1:0] {
    CS_PRI = 2'd0,
    CS_SEC = 2'd1,
    CS_NUC = 2'd2,
    CS_RSV = 2'd3
  } ctx_sel_e;

  function automatic logic [TTE_W-1:0] diag_view(input logic [TTE_W-1:0] w);
    logic [TTE_W-1:0] m;
    m = '0;
    for (int b = DZ_LO; b <= DZ_HI; b++) m[b] = 1'b1;
    return w & ~m;
  endfunction
endpackage

// File: rtl/tlb_ctx_regs.sv
module tlb_ctx_regs
  import tlb_pkg::*;
#(
  parameter int CTX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [63:0]      wdata,
  output logic [CTX_W-1:0] pri,
  output logic [CTX_W-1:0] sec
);
  logic [CTX_W-1:0] pri_q, pri_d, sec_q, sec_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[63:CTX_W];

  always_comb begin
    pri_d = pri_q;
    sec_d = sec_q;
    if (we && !sel) pri_d = wdata[CTX_W-1:0];
    if (we &&  sel) sec_d = wdata[CTX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
    end
  end

  assign pri = pri_q;
  assign sec = sec_q;

  // R4: a write lands in the chosen register, low bits only
  a_r4_pri_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel) |=> (pri == $past(wdata[CTX_W-1:0])));
  a_r4_sec_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> (sec == $past(wdata[CTX_W-1:0])));
  a_r4_pri_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(we && !sel)) |=> $stable(pri));
endmodule

// File: rtl/tlb_demap_dec.sv
module tlb_demap_dec
  import tlb_pkg::*;
#(
  parameter int CTX_W = 10
) (
  input  logic             req,
  input  logic [63:0]      addr,
  input  logic [CTX_W-1:0] pri,
  input  logic [CTX_W-1:0] sec,
  output dm_kind_e         kind,
  output logic [CTX_W-1:0] ctx,
  output logic [VPN_W-1:0] vpn
);
  ctx_sel_e sel;
  logic     unused_bits;

  assign sel         = ctx_sel_e'(addr[DM_SEL_LO +: 2]);
  assign vpn         = addr[TTE_W-1:PG_SH];
  assign unused_bits = ^{addr[PG_SH-1:DM_ALL_BIT+1], addr[DM_SEL_LO-1:0]};

  always_comb begin
    case (sel)
      CS_PRI:  ctx = pri;
      CS_SEC:  ctx = sec;
      default: ctx = '0;
    endcase
  end

  always_comb begin
    kind = DM_NONE;
    if (req) begin
      if (addr[DM_ALL_BIT])      kind = DM_ALL;
      else if (sel == CS_RSV)    kind = DM_NONE;
      else if (addr[DM_CTX_BIT]) kind = DM_CTX;
      else                       kind = DM_PAGE;
    end
  end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 10,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             lk_rvalid,
  output logic             lk_hit,
  output logic [TTE_W-1:0] lk_data,
  // diagnostic write (already address-qualified)
  input  logic             wr_en,
  input  logic             wr_tag,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TTE_W-1:0] wr_data,
  // diagnostic read
  input  logic             rd_en,
  input  logic             rd_tag,
  input  logic             rd_ok,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_rvalid,
  output logic [TTE_W-1:0] rd_data,
  // demap
  input  dm_kind_e         dm_kind,
  input  logic [VPN_W-1:0] dm_vpn,
  input  logic [CTX_W-1:0] dm_ctx
);
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [CTX_W-1:0] ctx_q [ENTRIES];
  logic [TTE_W-1:0] dat_q [ENTRIES];

  logic [ENTRIES-1:0] ent_v, ent_lock, lk_m, kill;
  logic               wr_eff;

  // a demap owns the array for its cycle; a colliding write is dropped
  assign wr_eff = wr_en && (dm_kind == DM_NONE);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] vpn_d;
    logic [CTX_W-1:0] ctx_d;
    logic [TTE_W-1:0] dat_d;
    logic             ctx_eq, pg_eq, wsel;

    assign ent_v[g]    = dat_q[g][B_VALID];
    assign ent_lock[g] = dat_q[g][B_LOCK];
    assign lk_m[g]     = ent_v[g] && (vpn_q[g] == lk_vpn) && (ctx_q[g] == lk_ctx);
    assign ctx_eq      = (ctx_q[g] == dm_ctx);
    assign pg_eq       = (vpn_q[g] == dm_vpn);
    assign wsel        = wr_eff && (wr_idx == IDX_W'(g));

    always_comb begin
      case (dm_kind)
        DM_PAGE: kill[g] = ent_v[g] && pg_eq && ctx_eq;
        DM_CTX:  kill[g] = ent_v[g] && ctx_eq;
        DM_ALL:  kill[g] = ent_v[g] && !ent_lock[g];
        default: kill[g] = 1'b0;
      endcase
    end

    always_comb begin
      vpn_d = vpn_q[g];
      ctx_d = ctx_q[g];
      dat_d = dat_q[g];
      if (wsel && wr_tag) begin
        vpn_d = wr_data[TTE_W-1:PG_SH];
        ctx_d = wr_data[CTX_W-1:0];
      end
      if (wsel && !wr_tag) dat_d = wr_data;
      if (kill[g]) dat_d[B_VALID] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q[g] <= '0;
        ctx_q[g] <= '0;
        dat_q[g] <= '0;
      end else begin
        vpn_q[g] <= vpn_d;
        ctx_q[g] <= ctx_d;
        dat_q[g] <= dat_d;
      end
    end

    // R9: a sweep of unlocked entries leaves locked ones valid
    a_r9_locked_spared: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_kind == DM_ALL && ent_v[g] && ent_lock[g]) |=> ent_v[g]);
    // R10: a write colliding with a demap leaves the word's payload untouched
    a_r10_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_kind != DM_NONE && wr_en && !wr_tag && wr_idx == IDX_W'(g))
      |=> (dat_q[g][TTE_W-2:0] == $past(dat_q[g][TTE_W-2:0])));
    // R8: a context sweep removes every entry of that context
    a_r8_ctx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_kind == DM_CTX && ctx_q[g] == dm_ctx) |=> !ent_v[g]);
  end

  // lookup: lowest matching index wins
  logic [IDX_W-1:0] lk_sel;
  logic             lk_any, lk_hit_d;
  logic [TTE_W-1:0] lk_data_d;

  always_comb begin
    lk_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_sel = IDX_W'(i);
    end
    lk_any    = |lk_m;
    lk_hit_d  = lk_any;
    lk_data_d = lk_any ? dat_q[lk_sel] : '0;
  end

  // diagnostic read view
  logic [TTE_W-1:0] rd_data_d;
  always_comb begin
    if (!rd_ok)      rd_data_d = '0;
    else if (rd_tag) rd_data_d = {vpn_q[rd_idx], {(PG_SH-CTX_W){1'b0}}, ctx_q[rd_idx]};
    else             rd_data_d = diag_view(dat_q[rd_idx]);
  end

  logic             lk_rvalid_q, lk_hit_q, rd_rvalid_q;
  logic [TTE_W-1:0] lk_data_q, rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rvalid_q <= 1'b0;
      lk_hit_q    <= 1'b0;
      lk_data_q   <= '0;
      rd_rvalid_q <= 1'b0;
      rd_data_q   <= '0;
    end else begin
      lk_rvalid_q <= lk_req;
      rd_rvalid_q <= rd_en;
      if (lk_req) begin
        lk_hit_q  <= lk_hit_d;
        lk_data_q <= lk_data_d;
      end
      if (rd_en) rd_data_q <= rd_data_d;
    end
  end

  assign lk_rvalid = lk_rvalid_q;
  assign lk_hit    = lk_hit_q;
  assign lk_data   = lk_data_q;
  assign rd_rvalid = rd_rvalid_q;
  assign rd_data   = rd_data_q;

  // R3: a reported hit always carries a valid translation
  a_r3_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rvalid && lk_hit) |-> lk_data[B_VALID]);
  // R2: a miss returns an all-zero word
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rvalid && !lk_hit) |-> (lk_data == '0));
  // R6: translation reads never expose the blanked window
  a_r6_blank_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_tag) |=> (rd_data[DZ_HI:DZ_LO] == '0));
endmodule

// File: rtl/tlb_fa_demap.sv
module tlb_fa_demap
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 10,
  parameter int DG_AW   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [50:0]      lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             lk_rvalid,
  output logic             lk_hit,
  output logic [63:0]      lk_data,
  output logic [4:0]       lk_attr,
  input  logic             dg_req,
  input  logic             dg_we,
  input  logic             dg_tag,
  input  logic [DG_AW-1:0] dg_addr,
  input  logic [63:0]      dg_wdata,
  output logic             dg_rvalid,
  output logic [63:0]      dg_rdata,
  input  logic             ctx_we,
  input  logic             ctx_sel,
  input  logic [63:0]      ctx_wdata,
  output logic [CTX_W-1:0] pri_ctx,
  output logic [CTX_W-1:0] sec_ctx,
  input  logic             dm_req,
  input  logic [63:0]      dm_addr,
  output logic             dm_busy
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // diagnostic address decode
  logic [IDX_W-1:0] dg_idx;
  logic [1:0]       dg_arr;
  logic             dg_ok, unused_dg;

  assign dg_idx    = dg_addr[DG_IDX_LO +: IDX_W];
  assign dg_arr    = dg_addr[DG_SEL_LO +: 2];
  assign dg_ok     = (dg_arr == 2'd0) && ({1'b0, dg_idx} < (IDX_W+1)'(ENTRIES));
  assign unused_dg = ^{dg_addr[DG_AW-1:DG_SEL_LO+2],
                       dg_addr[DG_SEL_LO-1:DG_IDX_LO+IDX_W],
                       dg_addr[DG_IDX_LO-1:0]};

  logic [CTX_W-1:0] pri_w, sec_w, dm_ctx;
  logic [VPN_W-1:0] dm_vpn;
  dm_kind_e         dm_kind;

  tlb_ctx_regs #(.CTX_W(CTX_W)) u_ctx (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctx_we),
    .sel   (ctx_sel),
    .wdata (ctx_wdata),
    .pri   (pri_w),
    .sec   (sec_w)
  );

  tlb_demap_dec #(.CTX_W(CTX_W)) u_dec (
    .req  (dm_req),
    .addr (dm_addr),
    .pri  (pri_w),
    .sec  (sec_w),
    .kind (dm_kind),
    .ctx  (dm_ctx),
    .vpn  (dm_vpn)
  );

  tlb_array #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_vpn    (lk_vpn),
    .lk_ctx    (lk_ctx),
    .lk_rvalid (lk_rvalid),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .wr_en     (dg_req && dg_we && dg_ok),
    .wr_tag    (dg_tag),
    .wr_idx    (dg_idx),
    .wr_data   (dg_wdata),
    .rd_en     (dg_req && !dg_we),
    .rd_tag    (dg_tag),
    .rd_ok     (dg_ok),
    .rd_idx    (dg_idx),
    .rd_rvalid (dg_rvalid),
    .rd_data   (dg_rdata),
    .dm_kind   (dm_kind),
    .dm_vpn    (dm_vpn),
    .dm_ctx    (dm_ctx)
  );

  assign lk_attr = {lk_data[B_LOCK], lk_data[B_CP], lk_data[B_CV],
                    lk_data[B_PRIV], lk_data[B_WR]};
  assign pri_ctx = pri_w;
  assign sec_ctx = sec_w;
  assign dm_busy = 1'b0;

  // R2: every lookup request is answered on the next cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_rvalid);
  // R5: a read aimed at another array returns zero
  a_r5_foreign_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dg_req && !dg_we && dg_arr != 2'd0) |=> (dg_rdata == '0));
endmodule

// File: tb/sim_tlb_fa_demap.sv
`timescale 1ns/1ps
module sim_tlb_fa_demap;
  localparam int CTX_W = 10;
  localparam int DG_AW = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_req;
  logic [50:0]      lk_vpn;
  logic [CTX_W-1:0] lk_ctx;
  logic             lk_rvalid, lk_hit;
  logic [63:0]      lk_data;
  logic [4:0]       lk_attr;
  logic             dg_req, dg_we, dg_tag;
  logic [DG_AW-1:0] dg_addr;
  logic [63:0]      dg_wdata;
  logic             dg_rvalid;
  logic [63:0]      dg_rdata;
  logic             ctx_we, ctx_sel;
  logic [63:0]      ctx_wdata;
  logic [CTX_W-1:0] pri_ctx, sec_ctx;
  logic             dm_req;
  logic [63:0]      dm_addr;
  logic             dm_busy;

  tlb_fa_demap #(.ENTRIES(16), .CTX_W(CTX_W), .DG_AW(DG_AW)) u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic        hit;
    logic [63:0] val;
    logic [4:0]  attr;
    string       req;
  } exp_t;

  exp_t lkq[$];
  exp_t dgq[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && lk_rvalid) begin
      if (lkq.size() == 0) chk("R2 unexpected lookup result", 64'd1, 64'd0);
      else begin
        e = lkq.pop_front();
        chk({e.req, " hit"},  {63'd0, lk_hit}, {63'd0, e.hit});
        chk({e.req, " data"}, lk_data, e.val);
        chk({e.req, " attr"}, {59'd0, lk_attr}, {59'd0, e.attr});
      end
    end
    if (rst_n && dg_rvalid) begin
      if (dgq.size() == 0) chk("R5 unexpected diag result", 64'd1, 64'd0);
      else begin
        e = dgq.pop_front();
        chk(e.req, dg_rdata, e.val);
      end
    end
  end

  function automatic logic [DG_AW-1:0] daddr(int idx, int arr);
    return DG_AW'(idx << 3) | (DG_AW'(arr) << 16);
  endfunction

  task automatic lookup(logic [50:0] v, logic [CTX_W-1:0] c, logic h,
                        logic [63:0] d, logic [4:0] a, string req);
    exp_t e;
    e.hit = h; e.val = d; e.attr = a; e.req = req;
    lkq.push_back(e);
    lk_req = 1'b1; lk_vpn = v; lk_ctx = c;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic dwrite(logic tg, int idx, int arr, logic [63:0] d);
    dg_req = 1'b1; dg_we = 1'b1; dg_tag = tg; dg_addr = daddr(idx, arr); dg_wdata = d;
    @(negedge clk);
    dg_req = 1'b0; dg_we = 1'b0;
  endtask

  task automatic dread(logic tg, int idx, int arr, logic [63:0] exp, string req);
    exp_t e;
    e.hit = 1'b0; e.val = exp; e.attr = '0; e.req = req;
    dgq.push_back(e);
    dg_req = 1'b1; dg_we = 1'b0; dg_tag = tg; dg_addr = daddr(idx, arr);
    @(negedge clk);
    dg_req = 1'b0;
  endtask

  task automatic cwrite(logic s, logic [63:0] d);
    ctx_we = 1'b1; ctx_sel = s; ctx_wdata = d;
    @(negedge clk);
    ctx_we = 1'b0;
  endtask

  task automatic demap(logic [63:0] a);
    dm_req = 1'b1; dm_addr = a;
    @(negedge clk);
    dm_req = 1'b0;
  endtask

  function automatic logic [63:0] tagw(logic [50:0] v, logic [CTX_W-1:0] c);
    return {v, 3'b000, c};
  endfunction

  localparam logic [50:0] VA = 51'h12345, VB = 51'h777, VC = 51'h999,
                          VE = 51'h10000, VF = 51'h4242, VG = 51'h55, VH = 51'h66;
  localparam logic [63:0] D0 = 64'h8000_2400_0ABC_2002;
  localparam logic [63:0] D3 = 64'h8000_0000_0000_4024;
  localparam logic [63:0] D5 = 64'h8000_0000_0000_6040;
  localparam logic [63:0] D7 = 64'h0000_0000_0000_8002;
  localparam logic [63:0] DE = 64'h8000_0000_000E_0050;
  localparam logic [63:0] DF = 64'h8000_0000_0000_F000;
  localparam logic [63:0] DG = 64'h8000_0000_0001_0000;
  localparam logic [63:0] DH = 64'h8000_0000_0002_0040;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lk_req = 0; lk_vpn = '0; lk_ctx = '0;
    dg_req = 0; dg_we = 0; dg_tag = 0; dg_addr = '0; dg_wdata = '0;
    ctx_we = 0; ctx_sel = 0; ctx_wdata = '0;
    dm_req = 0; dm_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 primary after reset", {54'd0, pri_ctx}, 64'd0);
    chk("R1 secondary after reset", {54'd0, sec_ctx}, 64'd0);
    chk("R1 no result valid", {62'd0, lk_rvalid, dg_rvalid}, 64'd0);
    chk("R10 busy low at reset", {63'd0, dm_busy}, 64'd0);
    lookup(51'd0, 10'd0, 1'b0, 64'd0, 5'd0, "R1 empty array misses");

    // R4 context registers keep low 10 bits
    cwrite(1'b0, 64'hFFFF_FFFF_FFFF_F123);
    chk("R4 primary low bits", {54'd0, pri_ctx}, 64'h123);
    cwrite(1'b1, 64'hABCD_EC05);
    chk("R4 secondary low bits", {54'd0, sec_ctx}, 64'h005);
    chk("R4 primary unchanged by secondary write", {54'd0, pri_ctx}, 64'h123);

    // load entries
    dwrite(1'b1, 0, 0, tagw(VA, 10'h123));  dwrite(1'b0, 0, 0, D0);
    dwrite(1'b1, 3, 0, tagw(VB, 10'd5));    dwrite(1'b0, 3, 0, D3);
    dwrite(1'b1, 5, 0, tagw(VB, 10'd5));    dwrite(1'b0, 5, 0, D5);
    dwrite(1'b1, 7, 0, tagw(VC, 10'h123));  dwrite(1'b0, 7, 0, D7);
    dwrite(1'b1, 15, 0, tagw(VE, 10'd0));   dwrite(1'b0, 15, 0, DE);
    dwrite(1'b1, 9, 0, tagw(VF, 10'd0));    dwrite(1'b0, 9, 0, DF);
    dwrite(1'b1, 10, 0, tagw(VG, 10'd1));   dwrite(1'b0, 10, 0, DG);
    dwrite(1'b1, 11, 0, tagw(VH, 10'd2));   dwrite(1'b0, 11, 0, DH);

    // R5 / R6 diagnostic readback
    dread(1'b0, 0, 0, 64'h8000_0000_0ABC_2002, "R6 data read blanks 49:41");
    dread(1'b1, 0, 0, tagw(VA, 10'h123), "R5 tag read entry 0");
    dread(1'b1, 15, 0, tagw(VE, 10'd0), "R5 tag read entry 15");

    // R2 / R3 lookups
    lookup(VA, 10'h123, 1'b1, D0, 5'b00001, "R2 hit returns unmasked word");
    lookup(VA, 10'h124, 1'b0, 64'd0, 5'd0, "R2 context mismatch misses");
    lookup(VB, 10'd5, 1'b1, D3, 5'b01010, "R3 lowest index wins");
    lookup(VC, 10'h123, 1'b0, 64'd0, 5'd0, "R3 invalid entry never hits");
    lookup(VE, 10'd0, 1'b1, DE, 5'b10100, "R2 last index hit");

    // R5 foreign array select
    dwrite(1'b0, 0, 1, 64'd0);
    dread(1'b0, 0, 0, 64'h8000_0000_0ABC_2002, "R5 foreign write ignored");
    dread(1'b0, 0, 2, 64'd0, "R5 foreign read returns zero");

    // R7 page demap
    demap({VA, 13'h30});
    lookup(VA, 10'h123, 1'b1, D0, 5'b00001, "R7 reserved selector no effect");
    demap({VA, 13'h10});
    lookup(VA, 10'h123, 1'b1, D0, 5'b00001, "R7 secondary context spares entry");
    demap({VA, 13'h00});
    lookup(VA, 10'h123, 1'b0, 64'd0, 5'd0, "R7 primary page removed");
    demap({VF, 13'h20});
    lookup(VF, 10'd0, 1'b0, 64'd0, 5'd0, "R7 nucleus page removed");
    lookup(VE, 10'd0, 1'b1, DE, 5'b10100, "R7 other nucleus page kept");

    // R8 context demap on secondary (5), locked entry included
    demap(64'h50);
    lookup(VB, 10'd5, 1'b0, 64'd0, 5'd0, "R8 context demap clears both");
    dread(1'b0, 5, 0, 64'h0000_0000_0000_6040, "R8 locked entry invalidated");

    // R9 + R10: all-unlocked demap colliding with a diag write
    dm_req = 1'b1; dm_addr = 64'h80;
    dg_req = 1'b1; dg_we = 1'b1; dg_tag = 1'b0; dg_addr = daddr(12, 0);
    dg_wdata = 64'h8000_0000_0000_1234;
    @(negedge clk);
    dm_req = 1'b0; dg_req = 1'b0; dg_we = 1'b0;
    lookup(VG, 10'd1, 1'b0, 64'd0, 5'd0, "R9 unlocked entry removed");
    lookup(VH, 10'd2, 1'b1, DH, 5'b10000, "R9 locked entry kept");
    lookup(VE, 10'd0, 1'b1, DE, 5'b10100, "R9 locked last entry kept");
    dread(1'b0, 12, 0, 64'd0, "R10 write dropped under demap");
    chk("R10 busy stays low", {63'd0, dm_busy}, 64'd0);

    repeat (3) @(negedge clk);
    chk("R2 all lookup results seen", 64'(lkq.size()), 64'd0);
    chk("R5 all diag results seen", 64'(dgq.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule